// File: doc/BRIEF.md
# Hardwired Step Sequencer for a Single-Bus Processor

This block is the hardwired control unit of a 32-bit processor whose datapath shares one internal bus. A step counter walks through T1, T2, T3 and onward. In each step the block combines the step number, the opcode and register fields taken from the instruction register, and the zero and negative flags. From these it drives every control line of the datapath: bus output enables, register loads, the ALU function, the constant-4 select, memory read and write, and wait-for-memory. When an instruction has finished, the block raises a finish strobe and the counter goes back to T1, so the next fetch begins.

Fetch takes three steps. The PC+4 sum is formed in T1, and the PC is reloaded from Z in T2 while the memory read is still in progress. Each of the sixteen instructions then uses one to three execution steps. A conditional branch whose condition fails finishes at T4, so the PC keeps the already incremented value. While wait-for-memory is asserted and memory has not reported completion, the counter holds and every control line stays as it is. The datapath, the register file and the memory are outside this block.

Top module: `hwseq_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `step` is 1 and the outputs show the T1 fetch set.
- R2: Fetch is the same for every instruction, whatever the value of `ir_top`. T1 raises pc_out, mar_in, mem_rd, sel_four and z_in, with alu_fn=0. T2 raises z_out, pc_in, y_in, wmfc and mdr_in_ext. T3 raises mdr_out and ir_in.
- R3: In a step with wmfc high, while `mfc` is low, `step` and every control output keep their values. The counter advances in the first cycle with `mfc` high.
- R4: In a cycle with `end_step` high and no hold, `step` is 1 in the next cycle. Otherwise, with no hold, `step` rises by one.
- R5: Register copy (op 0, Ry<=Rx) has one execution step: gpr_out with sel=Rx, and gpr_in with sel=Ry, plus end. Load immediate (op 1) has one execution step: off_out, and gpr_in with sel=Ry, plus end.
- R6: Load indirect (op 2, Ry<=mem[Rx]) runs three steps. T4: gpr_out with sel=Rx, mar_in, mem_rd. T5: mdr_in_ext, wmfc. T6: mdr_out, and gpr_in with sel=Ry, plus end.
- R7: Store indirect (op 3, mem[Ry]<=Rx) runs three steps. T4: gpr_out with sel=Ry, mar_in. T5: gpr_out with sel=Rx, mdr_in_int. T6: mem_wr, wmfc, end.
- R8: Two-operand ops (ops 4 to 7, Ry<=Ry op Rx, alu_fn 0=add, 1=sub, 2=and, 3=or) run three steps. T4: gpr_out with sel=Ry, y_in. T5: gpr_out with sel=Rx, z_in, the function, sel_four low. T6: z_out, and gpr_in with sel=Ry, plus end.
- R9: Single-operand ops (op 8 increment with alu_fn 4, op 9 invert with alu_fn 5, op 10 shift left with alu_fn 6) run two steps. T4: gpr_out with sel=Ry, z_in, the function. T5: z_out, and gpr_in with sel=Ry, plus end.
- R10: Compare (op 11) runs two steps. T4: off_out, y_in. T5: gpr_out with sel=Ry, alu_fn=1, end. It loads no register.
- R11: A taken branch runs two steps. T4: off_out, z_in, alu_fn=0. T5: z_out, pc_in, end. Op 12 is always taken.
- R12: Op 13 (taken when flag_z=1), op 14 (taken when flag_z=0) and op 15 (taken when flag_n=1) raise end_step already at T4 when the condition fails, and never raise pc_in in that instruction.
- R13: In every cycle at most one of pc_out, z_out, mdr_out, off_out and gpr_out is high, and mem_rd and mem_wr are never high together.
- R14: `ir_top` carries instruction bits 31..18. The opcode is in `ir_top[13:10]`, Ry in `[9:5]` and Rx in `[4:0]`. The opcode numbers are the ones given in R5 to R12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_top | input | 14 | Upper instruction register bits: opcode, Ry, Rx |
| flag_z | input | 1 | Zero flag from the datapath |
| flag_n | input | 1 | Negative flag from the datapath |
| mfc | input | 1 | Memory function complete |
| step | output | 3 | Current step number, 1 = T1 |
| pc_out | output | 1 | PC drives the bus |
| pc_in | output | 1 | PC loads from the bus |
| mar_in | output | 1 | Address register loads |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| wmfc | output | 1 | Wait for memory completion |
| mdr_in_ext | output | 1 | Data register loads from the memory data bus |
| mdr_in_int | output | 1 | Data register loads from the internal bus |
| mdr_out | output | 1 | Data register drives the bus |
| ir_in | output | 1 | Instruction register loads |
| y_in | output | 1 | Y operand register loads |
| z_in | output | 1 | Z result register loads |
| z_out | output | 1 | Z drives the bus |
| off_out | output | 1 | Instruction offset field drives the bus |
| sel_four | output | 1 | ALU A input takes constant 4 instead of Y |
| gpr_out | output | 1 | Selected general register drives the bus |
| gpr_out_sel | output | 5 | Register index that drives the bus |
| gpr_in | output | 1 | Selected general register loads |
| gpr_in_sel | output | 5 | Register index that loads |
| alu_fn | output | 3 | ALU function code |
| end_step | output | 1 | Instruction finishes this step |

## Verification
The counter is the only state, so a wrong step value appears on `step` and on the whole control vector in the same cycle. A count that skips or repeats a step shows within one cycle as a missing or doubled register load. A finish strobe that comes too early or too late desynchronises the whole sequence of the next instruction from its expected fetch pattern. A hold that ignores `mfc` shows as the T3 pattern appearing while memory is still busy. A flag test with the wrong sense shows at T4 of a conditional branch, either as a missing finish strobe or as a stray `pc_in` at T5.

// File: rtl/hwseq_pkg.sv
package hwseq_pkg;
  parameter int OP_W   = 4;
  parameter int RSEL_W = 5;
  parameter int ALU_W  = 3;
  parameter int HDR_W  = OP_W + 2 * RSEL_W;

  typedef enum logic [OP_W-1:0] {
    OP_MOVR = 4'h0, OP_MOVI, OP_LDX, OP_STX,
    OP_ADD,  OP_SUB,  OP_AND, OP_OR,
    OP_INC,  OP_NOT,  OP_SHL, OP_CMP,
    OP_JMP,  OP_JZ,   OP_JNZ, OP_JN
  } op_e;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 3'd0, ALU_SUB, ALU_AND, ALU_OR, ALU_INC, ALU_NOT, ALU_SHL
  } alu_e;

  typedef struct packed {
    logic              pc_out;
    logic              pc_in;
    logic              mar_in;
    logic              rd;
    logic              wr;
    logic              wmfc;
    logic              mdr_in_ext;
    logic              mdr_in_int;
    logic              mdr_out;
    logic              ir_in;
    logic              y_in;
    logic              z_in;
    logic              z_out;
    logic              off_out;
    logic              sel_four;
    logic              gpr_out;
    logic [RSEL_W-1:0] gpr_out_sel;
    logic              gpr_in;
    logic [RSEL_W-1:0] gpr_in_sel;
    alu_e              alu_fn;
    logic              fin;
  } ctl_t;
endpackage

// File: rtl/hwseq_ir_fields.sv
module hwseq_ir_fields
  import hwseq_pkg::*;
(
  input  logic [HDR_W-1:0]  ir_top,
  output op_e               op,
  output logic [RSEL_W-1:0] ry,
  output logic [RSEL_W-1:0] rx
);
  localparam int OP_LSB = HDR_W - OP_W;
  localparam int RY_LSB = OP_LSB - RSEL_W;

  assign op = op_e'(ir_top[OP_LSB +: OP_W]);
  assign ry = ir_top[RY_LSB +: RSEL_W];
  assign rx = ir_top[0 +: RSEL_W];
endmodule

// File: rtl/hwseq_step_ctr.sv
module hwseq_step_ctr #(
  parameter int STEP_W   = 3,
  parameter int MAX_STEP = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wmfc,
  input  logic              mfc,
  input  logic              fin,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] FIRST = STEP_W'(1);
  localparam logic [STEP_W-1:0] LAST  = STEP_W'(MAX_STEP);

  logic hold;
  assign hold = wmfc & ~mfc;

  always_ff @(posedge clk) begin
    if (rst)        step <= FIRST;
    else if (!hold) step <= fin ? FIRST : step + FIRST;
  end

  assert_restart_after_end_R4: assert property (@(posedge clk) disable iff (rst)
    (fin && !hold) |=> step == FIRST);
  assert_advance_by_one_R4: assert property (@(posedge clk) disable iff (rst)
    (!fin && !hold) |=> step == $past(step) + FIRST);
  assert_hold_on_wait_R3: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(step));
  assert_step_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    step >= FIRST && step <= LAST);
endmodule

// File: rtl/hwseq_ctl_matrix.sv
module hwseq_ctl_matrix
  import hwseq_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic [STEP_W-1:0] step,
  input  op_e               op,
  input  logic [RSEL_W-1:0] ry,
  input  logic [RSEL_W-1:0] rx,
  input  logic              flag_z,
  input  logic              flag_n,
  output ctl_t              c
);
  localparam logic [STEP_W-1:0] T1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] T2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] T3 = STEP_W'(3);
  localparam logic [STEP_W-1:0] T4 = STEP_W'(4);
  localparam logic [STEP_W-1:0] T5 = STEP_W'(5);
  localparam logic [STEP_W-1:0] T6 = STEP_W'(6);

  logic br_fail;
  alu_e op_fn;

  always_comb begin
    case (op)
      OP_JZ:   br_fail = ~flag_z;
      OP_JNZ:  br_fail = flag_z;
      OP_JN:   br_fail = ~flag_n;
      default: br_fail = 1'b0;
    endcase
    case (op)
      OP_SUB:  op_fn = ALU_SUB;
      OP_AND:  op_fn = ALU_AND;
      OP_OR:   op_fn = ALU_OR;
      OP_INC:  op_fn = ALU_INC;
      OP_NOT:  op_fn = ALU_NOT;
      OP_SHL:  op_fn = ALU_SHL;
      default: op_fn = ALU_ADD;
    endcase
  end

  always_comb begin
    c = '0;
    c.alu_fn = ALU_ADD;
    if (step == T1) begin
      c.pc_out = 1'b1; c.mar_in = 1'b1; c.rd = 1'b1;
      c.sel_four = 1'b1; c.z_in = 1'b1;
    end else if (step == T2) begin
      c.z_out = 1'b1; c.pc_in = 1'b1; c.y_in = 1'b1;
      c.wmfc = 1'b1; c.mdr_in_ext = 1'b1;
    end else if (step == T3) begin
      c.mdr_out = 1'b1; c.ir_in = 1'b1;
    end else begin
      case (op)
        OP_MOVR: if (step == T4) begin
          c.gpr_out = 1'b1; c.gpr_out_sel = rx;
          c.gpr_in = 1'b1; c.gpr_in_sel = ry; c.fin = 1'b1;
        end
        OP_MOVI: if (step == T4) begin
          c.off_out = 1'b1; c.gpr_in = 1'b1; c.gpr_in_sel = ry; c.fin = 1'b1;
        end
        OP_LDX: begin
          if (step == T4) begin
            c.gpr_out = 1'b1; c.gpr_out_sel = rx; c.mar_in = 1'b1; c.rd = 1'b1;
          end else if (step == T5) begin
            c.mdr_in_ext = 1'b1; c.wmfc = 1'b1;
          end else if (step == T6) begin
            c.mdr_out = 1'b1; c.gpr_in = 1'b1; c.gpr_in_sel = ry; c.fin = 1'b1;
          end
        end
        OP_STX: begin
          if (step == T4) begin
            c.gpr_out = 1'b1; c.gpr_out_sel = ry; c.mar_in = 1'b1;
          end else if (step == T5) begin
            c.gpr_out = 1'b1; c.gpr_out_sel = rx; c.mdr_in_int = 1'b1;
          end else if (step == T6) begin
            c.wr = 1'b1; c.wmfc = 1'b1; c.fin = 1'b1;
          end
        end
        OP_ADD, OP_SUB, OP_AND, OP_OR: begin
          if (step == T4) begin
            c.gpr_out = 1'b1; c.gpr_out_sel = ry; c.y_in = 1'b1;
          end else if (step == T5) begin
            c.gpr_out = 1'b1; c.gpr_out_sel = rx; c.z_in = 1'b1; c.alu_fn = op_fn;
          end else if (step == T6) begin
            c.z_out = 1'b1; c.gpr_in = 1'b1; c.gpr_in_sel = ry; c.fin = 1'b1;
          end
        end
        OP_INC, OP_NOT, OP_SHL: begin
          if (step == T4) begin
            c.gpr_out = 1'b1; c.gpr_out_sel = ry; c.z_in = 1'b1; c.alu_fn = op_fn;
          end else if (step == T5) begin
            c.z_out = 1'b1; c.gpr_in = 1'b1; c.gpr_in_sel = ry; c.fin = 1'b1;
          end
        end
        OP_CMP: begin
          if (step == T4) begin
            c.off_out = 1'b1; c.y_in = 1'b1;
          end else if (step == T5) begin
            c.gpr_out = 1'b1; c.gpr_out_sel = ry; c.alu_fn = ALU_SUB; c.fin = 1'b1;
          end
        end
        default: begin
          if (step == T4) begin
            c.off_out = 1'b1; c.z_in = 1'b1; c.fin = br_fail;
          end else if (step == T5) begin
            c.z_out = 1'b1; c.pc_in = 1'b1; c.fin = 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/hwseq_ctrl.sv
module hwseq_ctrl
  import hwseq_pkg::*;
#(
  parameter int STEP_W   = 3,
  parameter int MAX_STEP = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HDR_W-1:0]  ir_top,
  input  logic              flag_z,
  input  logic              flag_n,
  input  logic              mfc,
  output logic [STEP_W-1:0] step,
  output logic              pc_out,
  output logic              pc_in,
  output logic              mar_in,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              wmfc,
  output logic              mdr_in_ext,
  output logic              mdr_in_int,
  output logic              mdr_out,
  output logic              ir_in,
  output logic              y_in,
  output logic              z_in,
  output logic              z_out,
  output logic              off_out,
  output logic              sel_four,
  output logic              gpr_out,
  output logic [RSEL_W-1:0] gpr_out_sel,
  output logic              gpr_in,
  output logic [RSEL_W-1:0] gpr_in_sel,
  output logic [ALU_W-1:0]  alu_fn,
  output logic              end_step
);
  op_e               op;
  logic [RSEL_W-1:0] ry;
  logic [RSEL_W-1:0] rx;
  ctl_t              c;

  hwseq_ir_fields u_fields (
    .ir_top (ir_top),
    .op     (op),
    .ry     (ry),
    .rx     (rx)
  );

  hwseq_step_ctr #(.STEP_W(STEP_W), .MAX_STEP(MAX_STEP)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .wmfc (c.wmfc),
    .mfc  (mfc),
    .fin  (c.fin),
    .step (step)
  );

  hwseq_ctl_matrix #(.STEP_W(STEP_W)) u_matrix (
    .step   (step),
    .op     (op),
    .ry     (ry),
    .rx     (rx),
    .flag_z (flag_z),
    .flag_n (flag_n),
    .c      (c)
  );

  assign pc_out      = c.pc_out;
  assign pc_in       = c.pc_in;
  assign mar_in      = c.mar_in;
  assign mem_rd      = c.rd;
  assign mem_wr      = c.wr;
  assign wmfc        = c.wmfc;
  assign mdr_in_ext  = c.mdr_in_ext;
  assign mdr_in_int  = c.mdr_in_int;
  assign mdr_out     = c.mdr_out;
  assign ir_in       = c.ir_in;
  assign y_in        = c.y_in;
  assign z_in        = c.z_in;
  assign z_out       = c.z_out;
  assign off_out     = c.off_out;
  assign sel_four    = c.sel_four;
  assign gpr_out     = c.gpr_out;
  assign gpr_out_sel = c.gpr_out_sel;
  assign gpr_in      = c.gpr_in;
  assign gpr_in_sel  = c.gpr_in_sel;
  assign alu_fn      = c.alu_fn;
  assign end_step    = c.fin;

  assert_single_bus_driver_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_out, z_out, mdr_out, off_out, gpr_out}));
  assert_no_read_with_write_R13: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  assert_failed_branch_restarts_R12: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_W'(4) && ((op == OP_JZ && !flag_z) || (op == OP_JNZ && flag_z) ||
                            (op == OP_JN && !flag_n))) |=> step == STEP_W'(1));
  assert_fetch_ignores_flags_R2: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_W'(1)) |=> step == STEP_W'(2));
endmodule

// File: tb/sim_hwseq_ctrl.sv
module sim_hwseq_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, flag_z, flag_n, mfc;
  logic [13:0] ir_top;
  logic [2:0]  step;
  logic pc_out, pc_in, mar_in, mem_rd, mem_wr, wmfc, mdr_in_ext, mdr_in_int;
  logic mdr_out, ir_in, y_in, z_in, z_out, off_out, sel_four, gpr_out, gpr_in, end_step;
  logic [4:0]  gpr_out_sel, gpr_in_sel;
  logic [2:0]  alu_fn;

  hwseq_ctrl u0 (
    .clk(clk), .rst(rst), .ir_top(ir_top), .flag_z(flag_z), .flag_n(flag_n), .mfc(mfc),
    .step(step), .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .wmfc(wmfc), .mdr_in_ext(mdr_in_ext), .mdr_in_int(mdr_in_int),
    .mdr_out(mdr_out), .ir_in(ir_in), .y_in(y_in), .z_in(z_in), .z_out(z_out),
    .off_out(off_out), .sel_four(sel_four), .gpr_out(gpr_out), .gpr_out_sel(gpr_out_sel),
    .gpr_in(gpr_in), .gpr_in_sel(gpr_in_sel), .alu_fn(alu_fn), .end_step(end_step)
  );

  typedef struct packed {
    logic [2:0] st;
    logic pco, pci, mari, rd, wr, wm, mdrx, mdri, mdro, iri, yi, zi, zo, offo, s4, go;
    logic [4:0] gos;
    logic gi;
    logic [4:0] gis;
    logic [2:0] alu;
    logic fin;
  } exp_t;

  typedef struct { exp_t v; string tag; } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  exp_t act;
  assign act = {step, pc_out, pc_in, mar_in, mem_rd, mem_wr, wmfc, mdr_in_ext, mdr_in_int,
                mdr_out, ir_in, y_in, z_in, z_out, off_out, sel_four, gpr_out, gpr_out_sel,
                gpr_in, gpr_in_sel, alu_fn, end_step};

  // Expected control set per step, written from the requirements (R2, R5..R12, R14 codes).
  function automatic exp_t expect_step(int s, logic [3:0] op, logic [4:0] ry, logic [4:0] rx,
                                       logic zf, logic nf);
    exp_t e = '0;
    logic taken;
    e.st = 3'(s);
    taken = (op == 4'd12) || (op == 4'd13 && zf) || (op == 4'd14 && !zf) ||
            (op == 4'd15 && nf);
    if (s == 1) begin e.pco = 1; e.mari = 1; e.rd = 1; e.s4 = 1; e.zi = 1; end
    else if (s == 2) begin e.zo = 1; e.pci = 1; e.yi = 1; e.wm = 1; e.mdrx = 1; end
    else if (s == 3) begin e.mdro = 1; e.iri = 1; end
    else if (op == 4'd0) begin e.go = 1; e.gos = rx; e.gi = 1; e.gis = ry; e.fin = 1; end
    else if (op == 4'd1) begin e.offo = 1; e.gi = 1; e.gis = ry; e.fin = 1; end
    else if (op == 4'd2) begin
      if (s == 4) begin e.go = 1; e.gos = rx; e.mari = 1; e.rd = 1; end
      else if (s == 5) begin e.mdrx = 1; e.wm = 1; end
      else begin e.mdro = 1; e.gi = 1; e.gis = ry; e.fin = 1; end
    end else if (op == 4'd3) begin
      if (s == 4) begin e.go = 1; e.gos = ry; e.mari = 1; end
      else if (s == 5) begin e.go = 1; e.gos = rx; e.mdri = 1; end
      else begin e.wr = 1; e.wm = 1; e.fin = 1; end
    end else if (op <= 4'd7) begin
      if (s == 4) begin e.go = 1; e.gos = ry; e.yi = 1; end
      else if (s == 5) begin e.go = 1; e.gos = rx; e.zi = 1; e.alu = 3'(op - 4'd4); end
      else begin e.zo = 1; e.gi = 1; e.gis = ry; e.fin = 1; end
    end else if (op <= 4'd10) begin
      if (s == 4) begin e.go = 1; e.gos = ry; e.zi = 1; e.alu = 3'(op - 4'd4); end
      else begin e.zo = 1; e.gi = 1; e.gis = ry; e.fin = 1; end
    end else if (op == 4'd11) begin
      if (s == 4) begin e.offo = 1; e.yi = 1; end
      else begin e.go = 1; e.gos = ry; e.alu = 3'd1; e.fin = 1; end
    end else begin
      if (s == 4) begin e.offo = 1; e.zi = 1; e.fin = !taken; end
      else begin e.zo = 1; e.pci = 1; e.fin = 1; end
    end
    return e;
  endfunction

  // Monitor: pops one expected item per cycle and checks bus exclusivity (R13).
  always @(negedge clk) begin
    item_t it;
    if (!rst) begin
      n_chk++;
      if ($countones({pc_out, z_out, mdr_out, off_out, gpr_out}) > 1 || (mem_rd && mem_wr)) begin
        n_fail++;
        $display("FAIL R13: drivers=%b rd=%b wr=%b expected at most one driver, no rd+wr",
                 {pc_out, z_out, mdr_out, off_out, gpr_out}, mem_rd, mem_wr);
      end
      if (q.size() > 0) begin
        it = q.pop_front();
        n_chk++;
        if (act !== it.v) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.v);
        end
      end
    end
  end

  // Driver: called one time unit after the edge that starts T1 of the instruction.
  task automatic run(input logic [3:0] op, input logic [4:0] ry, input logic [4:0] rx,
                     input logic zf, input logic nf, input int st_step, input int st_cnt,
                     input string tag);
    int s = 1;
    int left = st_cnt;
    bit done = 0;
    exp_t e;
    ir_top = {op, ry, rx};
    flag_z = zf;
    flag_n = nf;
    while (!done) begin
      e = expect_step(s, op, ry, rx, zf, nf);
      if (s == st_step && left > 0) begin
        mfc = 1'b0;
        left--;
        q.push_back('{e, "R3 wait hold"});
      end else begin
        mfc = 1'b1;
        q.push_back('{e, (s <= 3) ? "R2 fetch" : (e.fin ? {tag, " R4 end"} : tag)});
        if (e.fin) done = 1;
        else s++;
      end
      @(posedge clk);
      #1;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    exp_t e;
    rst = 1'b1; mfc = 1'b1; flag_z = 1'b0; flag_n = 1'b0; ir_top = 14'h3FFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    e = expect_step(1, 4'hF, 5'd31, 5'd31, 1'b0, 1'b0);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL R1 reset: actual %h expected %h", act, e);
    end
    @(posedge clk);
    #1;
    rst = 1'b0;
    // First cycle out of reset is T1 (R1); opcode values per R14.
    run(4'd0,  5'd3,  5'd9,  0, 0, 0, 0, "R5 copy");
    run(4'd1,  5'd7,  5'd0,  0, 0, 2, 3, "R5 immediate");
    run(4'd2,  5'd2,  5'd1,  0, 0, 5, 2, "R6 load indirect");
    run(4'd3,  5'd6,  5'd1,  0, 0, 6, 3, "R7 store");
    run(4'd4,  5'd1,  5'd3,  0, 0, 0, 0, "R8 add");
    run(4'd5,  5'd0,  5'd31, 1, 1, 0, 0, "R8 sub");
    run(4'd6,  5'd31, 5'd0,  0, 0, 0, 0, "R8 and");
    run(4'd7,  5'd12, 5'd20, 0, 1, 0, 0, "R8 or");
    run(4'd8,  5'd5,  5'd17, 0, 0, 0, 0, "R9 inc");
    run(4'd9,  5'd4,  5'd2,  1, 0, 0, 0, "R9 invert");
    run(4'd10, 5'd31, 5'd31, 0, 0, 0, 0, "R9 shift");
    run(4'd11, 5'd7,  5'd11, 0, 0, 0, 0, "R10 compare");
    run(4'd12, 5'd0,  5'd0,  0, 0, 0, 0, "R11 branch");
    run(4'd13, 5'd1,  5'd1,  1, 0, 0, 0, "R11 zero taken");
    run(4'd13, 5'd1,  5'd1,  0, 1, 0, 0, "R12 zero not taken");
    run(4'd14, 5'd2,  5'd2,  0, 0, 0, 0, "R11 nonzero taken");
    run(4'd14, 5'd2,  5'd2,  1, 1, 0, 0, "R12 nonzero not taken");
    run(4'd15, 5'd3,  5'd3,  0, 1, 0, 0, "R11 minus taken");
    run(4'd15, 5'd3,  5'd3,  1, 0, 0, 0, "R12 minus not taken");
    run(4'd0,  5'd31, 5'd0,  0, 0, 2, 1, "R5 copy after stall");
    repeat (2) @(posedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    summary();
    $finish;
  end
endmodule